// File: doc/BRIEF.md
# Register-Mapped Serial Port with Dual Queues

This block is an asynchronous serial transmitter and receiver that software reaches through four 16-bit registers on a simple write-strobe bus with combinational read data. Bytes to send are written into an eight-entry transmit queue. The transmitter drains the queue one frame at a time. Bytes taken off the line are placed in an eight-entry receive queue, and software removes them explicitly. The transmit and receive bit rates are set independently. The frame shape can be changed while the block runs: data width, parity and stop length.

Register addresses on `addr` are: 0 for data/status, 1 for the transmit divisor, 2 for the receive divisor and 3 for frame control. Every byte passes through a queue, and there is no path around them. A write to the data register changes a queue only when the matching request bit is set in the written word.

Top module: `uart_regs`

## Requirements
- R1: A read at address 0 returns the head of the receive queue in bits 7:0 (zero while that queue is empty). It also returns receive-empty in bit 8, receive-full in bit 9, transmit-empty in bit 11 and transmit-full in bit 12, with all other bits zero. A read at any other address returns zero.
- R2: In a write to address 0, bit 13 set pushes bits 7:0 into the transmit queue and bit 10 set removes the receive head. With a bit clear, that queue is left as it was.
- R3: A push into a full transmit queue is discarded, and a removal from an empty receive queue leaves the queue empty.
- R4: Each queue holds 8 bytes in arrival order, and its empty and full indications reflect a push or removal from the clock edge that performs it.
- R5: Address 1 sets the transmit bit period and address 2 sets the receive bit period, both in clock cycles, with 0 treated as 1. Both reset to CLK_HZ/BAUD rounded to nearest, which is 868 for the defaults.
- R6: Address 3 bits [7:4] give the data width, clamped to 5..8. Bits [3:2] give the stop length minus one. Bit 1 selects even parity and bit 0 enables parity. The reset format is 8 data bits, no parity, 1 stop bit.
- R7: The idle line is high. A frame is a low start bit, then data bits LSB first, then the parity bit if enabled, then high stop bits. The format and bit period are captured when the frame starts.
- R8: With even parity selected, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number.
- R9: The receiver synchronises the line and confirms a start bit at its middle. It samples each later bit at mid-period with the receive divisor and stores the data bits right-aligned with unused upper bits zero. It ignores the parity bit, and it keeps the byte only if the first stop bit reads high.
- R10: A byte received while the receive queue is full is dropped, and the queued bytes are kept unchanged.
- R11: After reset the line is high, both queues are empty and address 0 reads 0x0900.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| tx_o | output | 1 | Serial output |
| rx_i | input | 1 | Serial input |

## Verification
The assertions check the following on every cycle:
- Queue occupancy never passes its depth.
- A push into a full queue or a removal from an empty one leaves the queue unchanged.
- The transmitter stays idle while its queue is empty, and its bit index stays within the data width.
- A full receive queue stays full until software removes a byte.
- The frame format is at its reset value right after reset.

The following can be shown only by the bench's scenarios, because they concern the serial waveform and byte order:
- Frame shape at several data widths, parity modes and stop lengths.
- Mid-bit sampling of frames driven at the receive divisor.
- Discarding of frames with a bad stop bit.
- Order of data through both queues.

// File: rtl/uart_pkg.sv
package uart_pkg;

    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 16;

    localparam logic [1:0] A_DATA  = 2'd0;
    localparam logic [1:0] A_TXDIV = 2'd1;
    localparam logic [1:0] A_RXDIV = 2'd2;
    localparam logic [1:0] A_CTRL  = 2'd3;

    localparam int B_POP  = 10;
    localparam int B_PUSH = 13;

    // frame format, packed in the control register's bit order
    typedef struct packed {
        logic [3:0] nbits;
        logic [1:0] nstop;
        logic       even;
        logic       par_en;
    } fmt_t;

    localparam fmt_t FMT_RESET = '{nbits: 4'd8, nstop: 2'd0, even: 1'b0, par_en: 1'b0};

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} line_st_e;

    function automatic logic [3:0] clamp_bits(input logic [3:0] raw);
        if (raw < 4'd5) return 4'd5;
        if (raw > 4'd8) return 4'd8;
        return raw;
    endfunction

    function automatic logic [2:0] stop_bits(input fmt_t f);
        return {1'b0, f.nstop} + 3'd1;
    endfunction

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : d;
    endfunction

    function automatic logic [DIV_W-1:0] half_m1(input logic [DIV_W-1:0] d);
        logic [DIV_W-1:0] h;
        h = eff_div(d) >> 1;
        return (h == '0) ? '0 : h - 1'b1;
    endfunction

    function automatic logic par_bit(input logic [BYTE_W-1:0] d, input logic [3:0] n,
                                     input logic even);
        logic [BYTE_W-1:0] m;
        m = 8'hFF >> (4'd8 - n);
        return even ? ^(d & m) : ~^(d & m);
    endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            cnt <= cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= FULL_CNT);
    // R3
    full_push_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> $stable(cnt));
    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_t              fmt,
    input  logic [DIV_W-1:0]  div,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              tx
);
    line_st_e          st;
    fmt_t              f_q;
    logic [DIV_W-1:0]  div_q, cnt;
    logic [BYTE_W-1:0] sh;
    logic [3:0]        bi;
    logic [2:0]        si;
    logic              par_q;
    logic              tick;

    assign tick     = (cnt == div_q - 1'b1);
    assign fifo_pop = (st == S_IDLE) && !fifo_empty;

    always_comb begin
        case (st)
            S_START: tx = 1'b0;
            S_DATA:  tx = sh[0];
            S_PAR:   tx = par_q;
            default: tx = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            f_q   <= FMT_RESET;
            div_q <= {{(DIV_W-1){1'b0}}, 1'b1};
            cnt   <= '0;
            sh    <= '0;
            bi    <= '0;
            si    <= '0;
            par_q <= 1'b0;
        end else if (st == S_IDLE) begin
            if (!fifo_empty) begin
                st    <= S_START;
                f_q   <= fmt;
                div_q <= eff_div(div);
                cnt   <= '0;
                sh    <= fifo_data;
                bi    <= '0;
                si    <= '0;
                par_q <= par_bit(fifo_data, clamp_bits(fmt.nbits), fmt.even);
            end
        end else if (!tick) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
            if (st == S_START) begin
                st <= S_DATA;
            end else if (st == S_DATA) begin
                if (bi == clamp_bits(f_q.nbits) - 4'd1) begin
                    st <= f_q.par_en ? S_PAR : S_STOP;
                end else begin
                    bi <= bi + 4'd1;
                    sh <= sh >> 1;
                end
            end else if (st == S_PAR) begin
                st <= S_STOP;
            end else begin
                if (si == stop_bits(f_q) - 3'd1) st <= S_IDLE;
                else si <= si + 3'd1;
            end
        end
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && fifo_empty) |=> (st == S_IDLE));
    // R7
    bit_index_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_DATA) |-> (bi < clamp_bits(f_q.nbits)));

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        nbits,
    input  logic              par_en,
    input  logic [DIV_W-1:0]  div,
    input  logic              rx_in,
    input  logic              fifo_full,
    output logic              push,
    output logic [BYTE_W-1:0] rx_byte
);
    line_st_e          st;
    logic [1:0]        sy;
    logic              rx_s;
    logic [DIV_W-1:0]  div_q, hm_q, cnt;
    logic [3:0]        nb_q, bi;
    logic              pen_q;
    logic [BYTE_W-1:0] sh;
    logic              tick;

    assign rx_s    = sy[1];
    assign tick    = (cnt == div_q - 1'b1);
    assign push    = (st == S_STOP) && tick && rx_s && !fifo_full;
    assign rx_byte = sh;

    always_ff @(posedge clk) begin
        if (rst) sy <= 2'b11;
        else     sy <= {sy[0], rx_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            div_q <= {{(DIV_W-1){1'b0}}, 1'b1};
            hm_q  <= '0;
            cnt   <= '0;
            nb_q  <= 4'd8;
            pen_q <= 1'b0;
            bi    <= '0;
            sh    <= '0;
        end else begin
            case (st)
                S_IDLE: if (!rx_s) begin
                    st    <= S_START;
                    div_q <= eff_div(div);
                    hm_q  <= half_m1(div);
                    nb_q  <= nbits;
                    pen_q <= par_en;
                    cnt   <= '0;
                    bi    <= '0;
                    sh    <= '0;
                end
                S_START: begin
                    if (cnt == hm_q) begin
                        cnt <= '0;
                        st  <= rx_s ? S_IDLE : S_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                S_DATA: begin
                    if (tick) begin
                        cnt        <= '0;
                        sh[bi[2:0]] <= rx_s;
                        if (bi == nb_q - 4'd1) st <= pen_q ? S_PAR : S_STOP;
                        else                   bi <= bi + 4'd1;
                    end else cnt <= cnt + 1'b1;
                end
                S_PAR: begin
                    if (tick) begin
                        cnt <= '0;
                        st  <= S_STOP;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    if (tick) begin
                        cnt <= '0;
                        st  <= S_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // R9
    false_start_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_START && cnt == hm_q && rx_s) |=> (st == S_IDLE));

endmodule

// File: rtl/uart_regs.sv
module uart_regs
    import uart_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int BAUD       = 115_200,
    parameter int FIFO_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             tx_o,
    input  logic             rx_i
);
    localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'((CLK_HZ + BAUD / 2) / BAUD);

    logic [DIV_W-1:0]  txdiv_q, rxdiv_q;
    fmt_t              fmt_q;
    logic              push_req, pop_req;
    logic              tx_empty, tx_full, tx_pop;
    logic [BYTE_W-1:0] tx_head;
    logic              rx_empty, rx_full, rx_push;
    logic [BYTE_W-1:0] rx_head, rx_byte;

    assign push_req = wr_en && (addr == A_DATA) && wdata[B_PUSH];
    assign pop_req  = wr_en && (addr == A_DATA) && wdata[B_POP];

    always_ff @(posedge clk) begin
        if (rst) begin
            txdiv_q <= DIV_RESET;
            rxdiv_q <= DIV_RESET;
            fmt_q   <= FMT_RESET;
        end else if (wr_en) begin
            case (addr)
                A_TXDIV: txdiv_q <= wdata;
                A_RXDIV: rxdiv_q <= wdata;
                A_CTRL:  fmt_q   <= fmt_t'(wdata[7:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_DATA)
            rdata = {3'b000, tx_full, tx_empty, 1'b0, rx_full, rx_empty,
                     rx_empty ? 8'h00 : rx_head};
    end

    uart_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(push_req), .din(wdata[BYTE_W-1:0]),
        .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full)
    );

    uart_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte),
        .pop(pop_req), .dout(rx_head), .empty(rx_empty), .full(rx_full)
    );

    uart_tx u_tx (
        .clk(clk), .rst(rst), .fmt(fmt_q), .div(txdiv_q),
        .fifo_empty(tx_empty), .fifo_data(tx_head), .fifo_pop(tx_pop), .tx(tx_o)
    );

    uart_rx u_rx (
        .clk(clk), .rst(rst), .nbits(clamp_bits(fmt_q.nbits)), .par_en(fmt_q.par_en),
        .div(rxdiv_q), .rx_in(rx_i), .fifo_full(rx_full), .push(rx_push), .rx_byte(rx_byte)
    );

    // R10
    drop_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !pop_req) |=> rx_full);
    // R6
    fmt_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fmt_q == FMT_RESET && txdiv_q == DIV_RESET && rxdiv_q == DIV_RESET));

endmodule

// File: tb/uart_regs_tb.sv
module uart_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        tx_o;
    logic        rx_i = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    uart_regs u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tx_o(tx_o), .rx_i(rx_i)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int nb);
        return 8'hFF >> (8 - nb);
    endfunction

    function automatic int clampb(input int raw);
        return (raw < 5) ? 5 : (raw > 8) ? 8 : raw;
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input int nb, input bit even);
        return even ? ^(d & mask_of(nb)) : ~^(d & mask_of(nb));
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0; wdata = 16'h0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
        addr = 2'd0;
    endtask

    task automatic mon_tx(input int div, input int nb, input bit pen, input bit even,
                          input int nst, input logic [7:0] exp, input string req);
        int t;
        logic [7:0] d;
        t = 0;
        @(posedge clk); #1;
        while (tx_o !== 1'b0 && t < 100000) begin
            @(posedge clk); #1;
            t++;
        end
        if (t >= 100000) begin
            check({req, " no start bit"}, 16'(tx_o), 16'h0);
            return;
        end
        repeat (div / 2) @(posedge clk);
        #1 check({req, " start"}, 16'(tx_o), 16'h0);
        d = 8'h00;
        for (int i = 0; i < nb; i++) begin
            repeat (div) @(posedge clk);
            #1 d[i] = tx_o;
        end
        check({req, " data"}, {8'h0, d}, {8'h0, exp & mask_of(nb)});
        if (pen) begin
            repeat (div) @(posedge clk);
            #1 check({req, " R8 parity"}, 16'(tx_o), 16'(exp_par(exp, nb, even)));
        end
        for (int s = 0; s < nst; s++) begin
            repeat (div) @(posedge clk);
            #1 check({req, " stop"}, 16'(tx_o), 16'h1);
        end
    endtask

    task automatic drive_rx(input int div, input int nb, input bit pen, input bit even,
                            input int nst, input logic [7:0] d, input bit stop_ok);
        @(negedge clk);
        rx_i = 1'b0;
        repeat (div) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_i = d[i];
            repeat (div) @(negedge clk);
        end
        if (pen) begin
            rx_i = exp_par(d, nb, even);
            repeat (div) @(negedge clk);
        end
        rx_i = stop_ok;
        repeat (div) @(negedge clk);
        rx_i = 1'b1;
        repeat (div * nst) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        bus_rd(2'd0, v);
        check("R11 reset status", v, 16'h0900);
        check("R11 idle line", 16'(tx_o), 16'h1);
        // R1 other address reads zero
        bus_rd(2'd1, v);
        check("R1 non-data read", v, 16'h0000);

        // R5 R6 default divisor and format on transmit
        bus_wr(2'd0, 16'h2000 | 16'h00A5);
        mon_tx(868, 8, 1'b0, 1'b0, 1, 8'hA5, "R5 R6 R7 default tx");
        // R5 default receive divisor
        drive_rx(868, 8, 1'b0, 1'b0, 1, 8'h3C, 1'b1);
        bus_rd(2'd0, v);
        check("R5 R1 default rx", v, 16'h083C);
        bus_wr(2'd0, 16'h0400);
        bus_rd(2'd0, v);
        check("R2 pop", v, 16'h0900);

        // R2 write with no request bits changes nothing
        bus_wr(2'd0, 16'h00FF);
        repeat (20) @(posedge clk);
        #1 check("R2 no push line", 16'(tx_o), 16'h1);
        bus_rd(2'd0, v);
        check("R2 no push status", v, 16'h0900);
        // R3 removal from empty
        bus_wr(2'd0, 16'h0400);
        bus_rd(2'd0, v);
        check("R3 pop empty", v, 16'h0900);

        bus_wr(2'd1, 16'd8);
        bus_wr(2'd2, 16'd8);

        // R8 directed even parity on 0x07
        bus_wr(2'd3, 16'h0083);
        bus_wr(2'd0, 16'h2007);
        mon_tx(8, 8, 1'b1, 1'b1, 1, 8'h07, "R8 even");
        bus_wr(2'd3, 16'h0081);
        bus_wr(2'd0, 16'h2007);
        mon_tx(8, 8, 1'b1, 1'b0, 1, 8'h07, "R8 odd");

        // R6 R7 R9 random formats and data
        for (int it = 0; it < 12; it++) begin
            int raw, stf, nb;
            bit pen, even;
            logic [7:0] b;
            raw  = $urandom_range(0, 15);
            stf  = $urandom_range(0, 3);
            pen  = 1'($urandom_range(0, 1));
            even = 1'($urandom_range(0, 1));
            nb   = clampb(raw);
            b    = 8'($urandom_range(0, 255));
            bus_wr(2'd3, {8'h0, 4'(raw), 2'(stf), even, pen});
            bus_wr(2'd0, {8'h20, b});
            mon_tx(8, nb, pen, even, stf + 1, b, "R6 R7 random tx");
            b = 8'($urandom_range(0, 255));
            drive_rx(8, nb, pen, even, stf + 1, b, 1'b1);
            bus_rd(2'd0, v);
            check("R9 random rx", v, {8'h08, b & mask_of(nb)});
            bus_wr(2'd0, 16'h0400);
        end

        // R9 bad stop bit discarded, then recovery
        bus_wr(2'd3, 16'h0080);
        drive_rx(8, 8, 1'b0, 1'b0, 1, 8'h5A, 1'b0);
        repeat (16) @(negedge clk);
        bus_rd(2'd0, v);
        check("R9 bad stop dropped", v, 16'h0900);
        drive_rx(8, 8, 1'b0, 1'b0, 1, 8'hC3, 1'b1);
        bus_rd(2'd0, v);
        check("R9 recovery", v, 16'h08C3);
        bus_wr(2'd0, 16'h0400);

        // R4 R10 receive queue fill and overflow
        for (int i = 0; i < 9; i++) drive_rx(8, 8, 1'b0, 1'b0, 1, 8'(8'h10 + i), 1'b1);
        bus_rd(2'd0, v);
        check("R4 R10 rx full", v, 16'h0A10);
        for (int i = 0; i < 8; i++) begin
            bus_rd(2'd0, v);
            check("R4 R10 rx order", v[7:0], 16'(8'h10 + i));
            bus_wr(2'd0, 16'h0400);
            bus_rd(2'd0, v);
            check("R4 rx full cleared", 16'(v[9]), 16'h0);
        end
        check("R10 ninth dropped", 16'(v[8]), 16'h1);

        // R3 R4 transmit queue fill; push into full is discarded
        bus_wr(2'd1, 16'd50);
        fork
            begin
                for (int i = 0; i < 9; i++) mon_tx(50, 8, 1'b0, 1'b0, 1, 8'(8'h40 + i), "R4 tx order");
            end
            begin
                for (int i = 0; i < 9; i++) bus_wr(2'd0, 16'(16'h2040 + i));
                bus_rd(2'd0, v);
                check("R4 tx full", v, 16'h1100);
                bus_wr(2'd0, 16'h2099);
            end
        join
        repeat (700) @(posedge clk);
        #1 check("R3 full push ignored line", 16'(tx_o), 16'h1);
        bus_rd(2'd0, v);
        check("R3 full push ignored status", v, 16'h0900);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule